// File: doc/BRIEF.md
# Pad Wake Event Detector

This block stays awake while the rest of a chip sleeps. It watches a group of digital pad inputs and raises a wake request when an enabled pad meets its chosen condition. Each pad has one bit in each of three configuration registers: wake enable, edge select and invert. The edge-select and invert bits together choose one of four conditions: high level, low level, rising edge or falling edge.

Each pad input passes through a two-flop synchroniser. Every pad has a status bit that latches its condition, whether or not the pad is enabled. The wake request is the OR of the status bits whose enable bit is set. Software clears a status bit by writing a one to it. A separate clear input wipes all status bits at once.

A parameter mask marks which pads may wake the device. Enable bits for the excluded pads, such as pins in another voltage domain, always stay zero.

Top module: `wake_detector`

## Requirements
- R1: While `rst_n` is low, all three configuration registers and every status bit are zero, and `wakeReq` is low.
- R2: A write takes effect on the clock edge where `cfgWe` is high. `cfgSel` selects the target: 0 = enable, 1 = edge select, 2 = invert, 3 = write-one-to-clear of status. The three registers read back on `cfgEnable`, `cfgEdge` and `cfgInvert`.
- R3: For a pad whose bit in `WAKE_CAPABLE` is 0, the enable bit stays 0 whatever is written. The default mask excludes pad 7.
- R4: Edge 0, invert 0 selects high level: the status bit is set while the synchronised pad is 1.
- R5: Edge 0, invert 1 selects low level: the status bit is set while the synchronised pad is 0.
- R6: Edge 1, invert 0 selects rising edge: a 0-to-1 change sets the status bit. A pad that then stays high does not set the bit again after it is cleared.
- R7: Edge 1, invert 1 selects falling edge: a 1-to-0 change sets the status bit. The opposite edge has no effect.
- R8: A status bit stays set until it is cleared. Writing a one to it with `cfgSel` = 3 clears it, but a set condition present in the same cycle wins over the clear, so a level that is still present keeps its bit set.
- R9: A high `clrAll` clears every status bit on that clock edge, with the same priority as in R8.
- R10: `wakeReq` is high exactly when some status bit is set and its enable bit is set. A status bit still latches while its enable bit is 0.
- R11: A pad change applied before clock edge k first shows in `statusOut` after edge k+2, and not after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| padIn | input | NUM_PADS | Raw pad inputs |
| cfgWe | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Write target select |
| cfgData | input | NUM_PADS | Write data, one bit per pad |
| clrAll | input | 1 | Clear all status bits |
| cfgEnable | output | NUM_PADS | Wake enable register |
| cfgEdge | output | NUM_PADS | Edge select register |
| cfgInvert | output | NUM_PADS | Invert register |
| statusOut | output | NUM_PADS | Latched per-pad status |
| wakeReq | output | 1 | Wake request |

## Verification
The assertions assume that `cfgWe`, `cfgSel`, `cfgData` and `clrAll` change only away from the rising clock edge. They also assume that no status bit may drop unless that cycle's write-one-to-clear mask or `clrAll` covers it. The stimulus changes every input at the falling edge. It changes pad inputs only after the configuration is written, and it clears status after the synchroniser has settled. It also holds every pad at its idle level during reset, so no stray edge is left behind.

// File: rtl/wake_pkg.sv
package wake_pkg;

  localparam logic [1:0] SEL_ENABLE = 2'd0;
  localparam logic [1:0] SEL_EDGE   = 2'd1;
  localparam logic [1:0] SEL_INVERT = 2'd2;
  localparam logic [1:0] SEL_CLEAR  = 2'd3;

  typedef struct packed {
    logic wrEnable;
    logic wrEdge;
    logic wrInvert;
    logic clrSelect;
    logic clrAll;
  } wakeStrobes_t;

endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0][WIDTH-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      for (int s = STAGES - 1; s > 0; s--) begin
        chain[s] <= chain[s-1];
      end
      chain[0] <= d;
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/wake_ctrl.sv
module wake_ctrl
  import wake_pkg::*;
#(
  parameter int NUM_PADS = 8
) (
  input  logic                cfgWe,
  input  logic [1:0]          cfgSel,
  input  logic [NUM_PADS-1:0] cfgData,
  input  logic                clrAll,
  output wakeStrobes_t        strobes,
  output logic [NUM_PADS-1:0] clrMask
);
  always_comb begin
    strobes.wrEnable  = cfgWe && (cfgSel == SEL_ENABLE);
    strobes.wrEdge    = cfgWe && (cfgSel == SEL_EDGE);
    strobes.wrInvert  = cfgWe && (cfgSel == SEL_INVERT);
    strobes.clrSelect = cfgWe && (cfgSel == SEL_CLEAR);
    strobes.clrAll    = clrAll;
  end

  always_comb begin
    clrMask = '0;
    if (strobes.clrSelect) clrMask = clrMask | cfgData;
    if (strobes.clrAll)    clrMask = '1;
  end
endmodule

// File: rtl/wake_datapath.sv
module wake_datapath
  import wake_pkg::*;
#(
  parameter int                NUM_PADS     = 8,
  parameter int                SYNC_STAGES  = 2,
  parameter logic [NUM_PADS-1:0] WAKE_CAPABLE = '1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] padIn,
  input  wakeStrobes_t        strobes,
  input  logic [NUM_PADS-1:0] cfgData,
  input  logic [NUM_PADS-1:0] clrMask,
  output logic [NUM_PADS-1:0] enableQ,
  output logic [NUM_PADS-1:0] edgeQ,
  output logic [NUM_PADS-1:0] invertQ,
  output logic [NUM_PADS-1:0] statusQ,
  output logic                wakeReq
);
  logic [NUM_PADS-1:0] padCur;
  logic [NUM_PADS-1:0] padPrev;
  logic [NUM_PADS-1:0] setVec;

  wake_sync #(.WIDTH(NUM_PADS), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (padIn),
    .q    (padCur)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) padPrev <= '0;
    else        padPrev <= padCur;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enableQ <= '0;
      edgeQ   <= '0;
      invertQ <= '0;
    end else begin
      if (strobes.wrEnable) enableQ <= cfgData & WAKE_CAPABLE;
      if (strobes.wrEdge)   edgeQ   <= cfgData;
      if (strobes.wrInvert) invertQ <= cfgData;
    end
  end

  for (genvar p = 0; p < NUM_PADS; p++) begin : g_pad
    logic riseHit, fallHit, edgeHit, levelHit;
    always_comb begin
      riseHit  = padCur[p] && !padPrev[p];
      fallHit  = !padCur[p] && padPrev[p];
      edgeHit  = invertQ[p] ? fallHit : riseHit;
      levelHit = padCur[p] ^ invertQ[p];
      setVec[p] = edgeQ[p] ? edgeHit : levelHit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) statusQ <= '0;
    else        statusQ <= (statusQ & ~clrMask) | setVec;
  end

  assign wakeReq = |(statusQ & enableQ);
endmodule

// File: rtl/wake_detector.sv
module wake_detector
  import wake_pkg::*;
#(
  parameter int                  NUM_PADS     = 8,
  parameter logic [NUM_PADS-1:0] WAKE_CAPABLE = 8'h7F
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PADS-1:0] padIn,
  input  logic                cfgWe,
  input  logic [1:0]          cfgSel,
  input  logic [NUM_PADS-1:0] cfgData,
  input  logic                clrAll,
  output logic [NUM_PADS-1:0] cfgEnable,
  output logic [NUM_PADS-1:0] cfgEdge,
  output logic [NUM_PADS-1:0] cfgInvert,
  output logic [NUM_PADS-1:0] statusOut,
  output logic                wakeReq
);
  localparam int SYNC_STAGES = 2;

  wakeStrobes_t        strobes;
  logic [NUM_PADS-1:0] clrMask;

  wake_ctrl #(.NUM_PADS(NUM_PADS)) u_ctrl (
    .cfgWe  (cfgWe),
    .cfgSel (cfgSel),
    .cfgData(cfgData),
    .clrAll (clrAll),
    .strobes(strobes),
    .clrMask(clrMask)
  );

  wake_datapath #(
    .NUM_PADS    (NUM_PADS),
    .SYNC_STAGES (SYNC_STAGES),
    .WAKE_CAPABLE(WAKE_CAPABLE)
  ) u_dp (
    .clk    (clk),
    .rst_n  (rst_n),
    .padIn  (padIn),
    .strobes(strobes),
    .cfgData(cfgData),
    .clrMask(clrMask),
    .enableQ(cfgEnable),
    .edgeQ  (cfgEdge),
    .invertQ(cfgInvert),
    .statusQ(statusOut),
    .wakeReq(wakeReq)
  );
endmodule

// File: rtl/wake_checker.sv
module wake_checker #(
  parameter int                  NUM_PADS     = 8,
  parameter logic [NUM_PADS-1:0] WAKE_CAPABLE = 8'h7F
) (
  input logic                clk,
  input logic                rst_n,
  input logic                cfgWe,
  input logic [1:0]          cfgSel,
  input logic [NUM_PADS-1:0] cfgData,
  input logic                clrAll,
  input logic [NUM_PADS-1:0] cfgEnable,
  input logic [NUM_PADS-1:0] statusOut,
  input logic                wakeReq
);
  logic [NUM_PADS-1:0] clrVec;
  always_comb begin
    clrVec = (cfgWe && cfgSel == 2'd3) ? cfgData : '0;
    if (clrAll) clrVec = '1;
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |=> (statusOut == '0 && cfgEnable == '0 && !wakeReq));

  // R2
  enable_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgWe && cfgSel == 2'd0) |=> cfgEnable == ($past(cfgData) & WAKE_CAPABLE));

  // R3
  ineligible_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfgEnable & ~WAKE_CAPABLE) == '0);

  // R8
  sticky_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(statusOut) & ~$past(clrVec)) & ~statusOut) == '0));

  // R10
  wake_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wakeReq |-> (cfgEnable != '0 && statusOut != '0));
endmodule

bind wake_detector wake_checker #(
  .NUM_PADS    (NUM_PADS),
  .WAKE_CAPABLE(WAKE_CAPABLE)
) u_wake_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfgWe    (cfgWe),
  .cfgSel   (cfgSel),
  .cfgData  (cfgData),
  .clrAll   (clrAll),
  .cfgEnable(cfgEnable),
  .statusOut(statusOut),
  .wakeReq  (wakeReq)
);

// File: tb/test_wake_detector.sv
`timescale 1ns/1ps
module test_wake_detector;
  localparam int       N   = 8;
  localparam logic [7:0] CAP = 8'h7F;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] padIn = '0;
  logic         cfgWe = 1'b0;
  logic [1:0]   cfgSel = '0;
  logic [N-1:0] cfgData = '0;
  logic         clrAll = 1'b0;
  logic [N-1:0] cfgEnable, cfgEdge, cfgInvert, statusOut;
  logic         wakeReq;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  wake_detector #(.NUM_PADS(N), .WAKE_CAPABLE(CAP)) i_wake_detector (
    .clk(clk), .rst_n(rst_n), .padIn(padIn), .cfgWe(cfgWe), .cfgSel(cfgSel),
    .cfgData(cfgData), .clrAll(clrAll), .cfgEnable(cfgEnable), .cfgEdge(cfgEdge),
    .cfgInvert(cfgInvert), .statusOut(statusOut), .wakeReq(wakeReq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [N-1:0] data);
    @(negedge clk);
    cfgWe = 1'b1; cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0; cfgData = '0;
  endtask

  task automatic pulseClear();
    @(negedge clk);
    clrAll = 1'b1;
    @(negedge clk);
    clrAll = 1'b0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 status", statusOut, 0);
    check("R1 wake", wakeReq, 0);
    check("R1 enable", cfgEnable, 0);
    check("R1 edge/invert", {cfgEdge, cfgInvert}, 0);
    rst_n = 1'b1;

    // R2 register writes, R3 ineligible pad
    wr(2'd0, 8'hFF); check("R3 enable mask", cfgEnable, CAP);
    wr(2'd1, 8'hA5); check("R2 edge reg", cfgEdge, 8'hA5);
    wr(2'd2, 8'h3C); check("R2 invert reg", cfgInvert, 8'h3C);
    wr(2'd0, 8'h81); check("R3 pad7 ignored", cfgEnable, 8'h01);
    wr(2'd1, 8'h00); wr(2'd2, 8'h00); wr(2'd0, 8'h00);
    repeat (4) @(negedge clk);
    pulseClear();

    for (int i = 0; i < N; i++) begin
      for (int m = 0; m < 4; m++) begin
        logic edgeB, invB;
        logic [N-1:0] idle, bitI;
        string tag;
        edgeB = m[1]; invB = m[0];
        idle = invB ? '1 : '0;
        bitI = N'(1) << i;
        tag = (m == 0) ? "R4" : (m == 1) ? "R5" : (m == 2) ? "R6" : "R7";

        padIn = idle;
        wr(2'd1, edgeB ? '1 : '0);
        wr(2'd2, invB ? '1 : '0);
        wr(2'd0, bitI);
        repeat (4) @(negedge clk);
        pulseClear();
        check("R9 clear all", statusOut, 0);

        padIn = idle ^ bitI;
        @(posedge clk); @(posedge clk); @(negedge clk);
        check("R11 not yet", statusOut, 0);
        @(negedge clk);
        check(tag, statusOut, bitI);
        check("R10 wake", wakeReq, (bitI & CAP) != 0);

        wr(2'd3, bitI);
        check(edgeB ? "R6 no retrigger" : "R8 level beats clear", statusOut, edgeB ? 0 : bitI);

        padIn = idle;
        repeat (3) @(negedge clk);
        check(edgeB ? "R7 opposite edge" : "R8 sticky", statusOut, edgeB ? 0 : bitI);

        wr(2'd3, bitI);
        check("R8 cleared", statusOut, 0);
        check("R10 wake low", wakeReq, 0);
      end
    end

    // R10 status latches with enable off, wake follows enable
    padIn = '0;
    wr(2'd0, 8'h00); wr(2'd1, 8'hFF); wr(2'd2, 8'h00);
    repeat (4) @(negedge clk);
    pulseClear();
    padIn = 8'h04;
    repeat (3) @(negedge clk);
    check("R10 latched disabled", statusOut, 8'h04);
    check("R10 no wake disabled", wakeReq, 0);
    wr(2'd0, 8'h04);
    check("R10 wake on enable", wakeReq, 1);
    pulseClear();
    check("R9 clear drops wake", {statusOut, wakeReq}, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule